// File: doc/BRIEF.md
# Dual-Lane Ancillary Word Insertion Buffer

The block holds two small dual-clock FIFOs of 10-bit ancillary words. One feeds the luma channel of a 20-bit video word, the other the chroma channel. A user write port on its own clock loads them. The video pixel clock drains each FIFO into its channel, and it replaces the incoming video word in the cycle where a stored word is read. When no word is read, each channel carries the incoming video word. Both cases take one cycle of latency. A steering input chooses which FIFO a write goes to and, in external mode, which FIFO the read enable drains. All control inputs are active low except the steering, mode and timing inputs.

There are two operating modes. In external mode the user drives the FIFO reset and the read enable. In internal mode the block ignores both. It flushes the FIFOs when the horizontal ancillary interval ends, so that words written during the following active video are ready for the next line. At each line start it returns the read pointers to their start, and it reads both FIFOs at once while the ancillary interval input is high. Write and read pointers cross between the two clocks as registered Gray codes through two-flop synchronizers. A flush that starts on the pixel clock reaches the write side through a toggle handshake, and reads stay blocked until that handshake completes.

Top module: `anc_insert_fifo`

## Requirements
- R1: While `wen_n` is low on a rising `wclk` edge and the target FIFO is not full, `wdata` is stored in that FIFO. While `wen_n` is high, nothing is stored and the write pointer holds its value.
- R2: In external mode (`int_mode` low), `ren_n` low on a `pclk` edge reads the next word from the FIFO chosen by `sel_luma`, and the word appears on that channel of `dout` one cycle later. While `ren_n` is high, the read pointers hold their value.
- R3: A channel that has no word read in a given cycle shows, one cycle later, the matching slice of `din`.
- R4: `sel_luma` high selects the luma FIFO and luma channel `dout[19:10]`. `sel_luma` low selects the chroma FIFO and chroma channel `dout[9:0]`.
- R5: In external mode, `ffrst_n` low on a `pclk` edge empties both FIFOs, returning every read and write pointer to its start.
- R6: In internal mode, `ren_n` and `ffrst_n` have no effect. Both FIFOs are read together, one word per cycle each, and only while `hanc_active` is high.
- R7: In internal mode, `line_start` high returns both read pointers to the start without reading, so stored words are read again. A falling edge of `hanc_active` empties both FIFOs.
- R8: While `flag_en_n` is low, `y_empty`/`c_empty` are high for an empty FIFO and `y_full`/`c_full` are high for a FIFO holding 64 words. While `flag_en_n` is high, all four flags are low.
- R9: Each FIFO holds 64 words. A write to a full FIFO is dropped.
- R10: A read attempted on an empty FIFO leaves its read pointer unchanged, and the channel passes `din` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, both domains |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | 10 | Ancillary word to store |
| sel_luma | input | 1 | 1 = luma FIFO/channel, 0 = chroma |
| pclk | input | 1 | Pixel clock |
| ffrst_n | input | 1 | FIFO flush in external mode, active low |
| ren_n | input | 1 | Read enable in external mode, active low |
| int_mode | input | 1 | 1 = internal scheduling, 0 = external control |
| line_start | input | 1 | Line start pulse (internal mode) |
| hanc_active | input | 1 | High during the horizontal ancillary interval |
| flag_en_n | input | 1 | Status flag enable, active low |
| din | input | 20 | Incoming video word, luma in 19:10 |
| dout | output | 20 | Outgoing video word with inserted words |
| y_empty | output | 1 | Luma FIFO empty |
| y_full | output | 1 | Luma FIFO full |
| c_empty | output | 1 | Chroma FIFO empty |
| c_full | output | 1 | Chroma FIFO full |

## Verification
In internal mode a word read from one FIFO and a passed-through video word on the other channel can meet in the same output cycle. The bench provokes this by loading four luma words and six chroma words and holding `hanc_active` for longer than either FIFO needs. The luma channel then returns to `din` while chroma is still inserting. A line start pulse falls in the middle of the interval, so a rewind also meets active reading. A behavioural model built on counters and arrays predicts each channel separately on every pixel clock. The bench compares each channel at the falling edge against the model.

// File: rtl/anc_insert_fifo.sv
module anc_insert_fifo #(
  parameter int DW = 10,
  parameter int AW = 6
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] wdata,
  input  logic          sel_luma,
  input  logic          pclk,
  input  logic          ffrst_n,
  input  logic          ren_n,
  input  logic          int_mode,
  input  logic          line_start,
  input  logic          hanc_active,
  input  logic          flag_en_n,
  input  logic [2*DW-1:0] din,
  output logic [2*DW-1:0] dout,
  output logic          y_empty,
  output logic          y_full,
  output logic          c_empty,
  output logic          c_full
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic hanc_d, req_t, ack_t;
  logic [1:0] ack_s, req_s;
  logic [1:0] rd_v, wr_v, emp_v, ful_v;
  logic [2*PW-1:0] rb_v, wb_v;

  wire flush  = int_mode ? (hanc_d & ~hanc_active) : ~ffrst_n;
  wire rewind = int_mode & line_start;
  wire pend   = req_t ^ ack_s[1];
  wire wrst   = req_s[1] ^ ack_t;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      hanc_d <= 1'b0;
      req_t  <= 1'b0;
      ack_s  <= '0;
    end else begin
      hanc_d <= hanc_active;
      ack_s  <= {ack_s[0], ack_t};
      if (flush && !pend) req_t <= ~req_t;
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      req_s <= '0;
      ack_t <= 1'b0;
    end else begin
      req_s <= {req_s[0], req_t};
      ack_t <= req_s[1];
    end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam bit IS_Y = (g == 1);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray, rq1, rq2, wq1, wq2;
    logic [DW-1:0] dq;
    wire  [PW-1:0] wnx = wbin + 1'b1;
    wire  [PW-1:0] rnx = rbin + 1'b1;
    wire  sel   = (sel_luma == IS_Y);
    wire  full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    wire  empty = pend | (rgray == wq2);

    assign wr_v[g] = ~wen_n & sel & ~full & ~wrst;
    assign rd_v[g] = ~empty & ~flush & ~rewind &
                     (int_mode ? hanc_active : (~ren_n & sel));
    assign emp_v[g] = empty & ~flag_en_n;
    assign ful_v[g] = full & ~flag_en_n;
    assign rb_v[g*PW +: PW] = rbin;
    assign wb_v[g*PW +: PW] = wbin;
    assign dout[g*DW +: DW] = dq;

    always_ff @(posedge wclk)
      if (wr_v[g]) mem[wbin[AW-1:0]] <= wdata;

    always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
        wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      end else begin
        rq1 <= rgray;
        rq2 <= rq1;
        if (wrst) begin
          wbin <= '0; wgray <= '0;
        end else if (wr_v[g]) begin
          wbin  <= wnx;
          wgray <= wnx ^ (wnx >> 1);
        end
      end

    always_ff @(posedge pclk or negedge rst_n)
      if (!rst_n) begin
        rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; dq <= '0;
      end else begin
        wq1 <= wgray;
        wq2 <= wq1;
        dq  <= rd_v[g] ? mem[rbin[AW-1:0]] : din[g*DW +: DW];
        if (flush || rewind) begin
          rbin <= '0; rgray <= '0;
        end else if (rd_v[g]) begin
          rbin  <= rnx;
          rgray <= rnx ^ (rnx >> 1);
        end
      end
  end

  assign y_empty = emp_v[1];
  assign y_full  = ful_v[1];
  assign c_empty = emp_v[0];
  assign c_full  = ful_v[0];
endmodule

// File: rtl/anc_insert_fifo_chk.sv
module anc_insert_fifo_chk #(
  parameter int DW = 10,
  parameter int AW = 6
) (
  input logic          rst_n,
  input logic          pclk,
  input logic          wclk,
  input logic          int_mode,
  input logic          hanc_active,
  input logic          ren_n,
  input logic          ffrst_n,
  input logic          flag_en_n,
  input logic          wen_n,
  input logic [2*DW-1:0] din,
  input logic [2*DW-1:0] dout,
  input logic [1:0]    rd_v,
  input logic [2*(AW+1)-1:0] rb_v,
  input logic [2*(AW+1)-1:0] wb_v,
  input logic          y_empty,
  input logic          c_empty,
  input logic          y_full,
  input logic          c_full
);
  localparam int PW = AW + 1;

  a_r3_pass_luma: assert property (@(posedge pclk) disable iff (!rst_n)
    !rd_v[1] |=> dout[2*DW-1:DW] == $past(din[2*DW-1:DW]));

  a_r3_pass_chroma: assert property (@(posedge pclk) disable iff (!rst_n)
    !rd_v[0] |=> dout[DW-1:0] == $past(din[DW-1:0]));

  a_r2_read_hold: assert property (@(posedge pclk) disable iff (!rst_n)
    (!int_mode && ren_n && ffrst_n) |=> $stable(rb_v));

  a_r6_hanc_gate: assert property (@(posedge pclk) disable iff (!rst_n)
    (int_mode && !hanc_active) |-> rd_v == 2'b00);

  a_r8_mask_empty: assert property (@(posedge pclk) disable iff (!rst_n)
    flag_en_n |-> (!y_empty && !c_empty));

  a_r8_mask_full: assert property (@(posedge wclk) disable iff (!rst_n)
    flag_en_n |-> (!y_full && !c_full));

  a_r10_no_underflow: assert property (@(posedge pclk) disable iff (!rst_n)
    (!flag_en_n && (y_empty || c_empty)) |-> !(y_empty && rd_v[1]) && !(c_empty && rd_v[0]));

  a_r1_write_hold: assert property (@(posedge wclk) disable iff (!rst_n)
    wen_n |=> (wb_v[PW-1:0] == $past(wb_v[PW-1:0]) || wb_v[PW-1:0] == '0) &&
              (wb_v[2*PW-1:PW] == $past(wb_v[2*PW-1:PW]) || wb_v[2*PW-1:PW] == '0));

  a_r9_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (!flag_en_n && y_full) |=> (wb_v[2*PW-1:PW] == $past(wb_v[2*PW-1:PW]) || wb_v[2*PW-1:PW] == '0));
endmodule

bind anc_insert_fifo anc_insert_fifo_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/anc_insert_fifo_tb_top.sv
`timescale 1ns/1ps
module anc_insert_fifo_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, wen_n = 1'b1, sel_luma = 1'b0, ffrst_n = 1'b1, ren_n = 1'b1;
  logic int_mode = 1'b0, line_start = 1'b0, hanc_active = 1'b0, flag_en_n = 1'b0;
  logic [9:0] wdata = '0;
  logic [19:0] din = '0;
  logic [19:0] dout;
  logic y_empty, y_full, c_empty, c_full;

  anc_insert_fifo dut_i (
    .rst_n(rst_n), .wclk(clk), .wen_n(wen_n), .wdata(wdata), .sel_luma(sel_luma),
    .pclk(clk), .ffrst_n(ffrst_n), .ren_n(ren_n), .int_mode(int_mode),
    .line_start(line_start), .hanc_active(hanc_active), .flag_en_n(flag_en_n),
    .din(din), .dout(dout), .y_empty(y_empty), .y_full(y_full),
    .c_empty(c_empty), .c_full(c_full));

  int vectors = 0, fails = 0;
  string tag = "R3";

  logic [9:0] m [2][64];
  int wc [2];
  int rc [2];
  logic hp;
  logic [19:0] exp_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      wc[0] = 0; wc[1] = 0; rc[0] = 0; rc[1] = 0; hp = 1'b0; exp_q = '0;
    end else begin
      logic fl, rw, rd;
      logic [9:0] e [2];
      fl = int_mode ? (hp && !hanc_active) : !ffrst_n;
      rw = int_mode && line_start;
      for (int i = 0; i < 2; i++) begin
        rd = !fl && !rw && rc[i] < wc[i] &&
             (int_mode ? hanc_active : (!ren_n && (sel_luma == (i == 1))));
        e[i] = rd ? m[i][rc[i] % 64] : din[i*10 +: 10];
        if (rd) rc[i]++;
      end
      begin
        int s;
        s = sel_luma ? 1 : 0;
        if (!wen_n && (wc[s] - rc[s]) < 64) begin
          m[s][wc[s] % 64] = wdata;
          wc[s]++;
        end
      end
      if (fl) begin wc[0] = 0; wc[1] = 0; rc[0] = 0; rc[1] = 0; end
      if (rw) begin rc[0] = 0; rc[1] = 0; end
      hp = hanc_active;
      exp_q = {e[1], e[0]};
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (dout !== exp_q) begin
      fails++;
      $display("FAIL %s dout actual=%h expected=%h at %0t", tag, dout, exp_q, $time);
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      din = 20'($urandom);
    end
  endtask

  task automatic chk_flags(string t);
    logic [3:0] ex;
    ex = flag_en_n ? 4'b0000 :
         {wc[1] == rc[1], wc[1] - rc[1] == 64, wc[0] == rc[0], wc[0] - rc[0] == 64};
    vectors++;
    if ({y_empty, y_full, c_empty, c_full} !== ex) begin
      fails++;
      $display("FAIL %s flags actual=%b expected=%b", t, {y_empty, y_full, c_empty, c_full}, ex);
    end
  endtask

  task automatic wr(logic lane, int n, logic [9:0] base);
    sel_luma = lane;
    for (int k = 0; k < n; k++) begin
      wen_n = 1'b0; wdata = base + 10'(k);
      step();
    end
    wen_n = 1'b1;
  endtask

  task automatic rd_ext(logic lane, int n);
    sel_luma = lane;
    ren_n = 1'b0;
    step(n);
    ren_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(3);
    chk_flags("R8 reset");

    tag = "R1 R4 write";
    wr(1'b1, 5, 10'h120);
    wr(1'b0, 3, 10'h2A0);
    wen_n = 1'b1; wdata = 10'h3FF; step(3);
    step(8);
    chk_flags("R1 after writes");

    tag = "R2 R4 luma read";
    rd_ext(1'b1, 2);
    step(3);
    tag = "R2 R10 chroma read past empty";
    rd_ext(1'b0, 5);
    step(2);
    chk_flags("R10 chroma empty");
    tag = "R2 luma rest";
    rd_ext(1'b1, 3);
    step(8);
    chk_flags("R2 both empty");

    tag = "R5 flush";
    wr(1'b1, 4, 10'h055);
    step(8);
    ffrst_n = 1'b0; step(); ffrst_n = 1'b1;
    step(8);
    chk_flags("R5 flushed");
    rd_ext(1'b1, 3);

    tag = "R9 capacity";
    wr(1'b0, 66, 10'h100);
    step(8);
    chk_flags("R9 full");
    flag_en_n = 1'b1; step();
    chk_flags("R8 masked");
    flag_en_n = 1'b0; step();
    rd_ext(1'b0, 66);
    step(8);
    chk_flags("R9 drained");

    tag = "R6 R7 internal flush";
    int_mode = 1'b1;
    hanc_active = 1'b1; step(); hanc_active = 1'b0;
    step(8);
    tag = "R6 load, external controls ignored";
    wr(1'b1, 4, 10'h1C0);
    wr(1'b0, 6, 10'h0E0);
    ffrst_n = 1'b0; ren_n = 1'b0; step(2); ffrst_n = 1'b1; ren_n = 1'b1;
    step(8);
    chk_flags("R6 loaded");
    tag = "R7 line start";
    line_start = 1'b1; step(); line_start = 1'b0;
    tag = "R6 concurrent reads";
    hanc_active = 1'b1; step(2);
    tag = "R7 rewind mid interval";
    line_start = 1'b1; step(); line_start = 1'b0;
    tag = "R6 R3 luma drains first";
    step(8);
    hanc_active = 1'b0;
    tag = "R7 flush at end of interval";
    step(8);
    chk_flags("R7 emptied");
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule